// File: doc/BRIEF.md
# Raster-Operation Rectangle Blitter (8 bpp)

This block fills or copies a rectangle of 8-bit pixels in a frame buffer. Software programs a sixteen-byte register page with the rectangle size, the two row pitches, the destination and source start addresses, a mode byte, a mode-extension byte, a raster-operation code and two colours. It then writes the control byte to start the operation. The engine walks the rectangle one pixel at a time. For each pixel it may fetch a source byte and it always fetches the destination byte. It combines the two through the selected raster operation and writes the result back through a synchronous frame-buffer port. Read data on that port returns one cycle after the read strobe.

The pixel source is one of four kinds: a plain frame-buffer copy, a monochrome mask expanded to foreground or background colour, an 8x8 pattern tile, or 32-bit words pushed in by the host. A solid-fill option bypasses the source altogether. The rectangle can be walked forward or backward. A status byte reports when the engine is busy and when it is waiting for a host word. A reset command aborts a running operation at once.

Top module: `blit_engine`

## Requirements
- R1: While rst_n is low and right after reset, status is 0x00 and fb_re, fb_we and host_ready are all low.
- R2: A write of control register 0xF with bit 1 set (and bit 2 clear) while idle raises status bit 0 (busy) on the next cycle. Busy stays high until the last pixel is written. A solid fill therefore stays busy for exactly 2×W×H cycles, and a frame-buffer copy takes 3 cycles per pixel.
- R3: A control write with bit 2 set aborts at once: busy is low on the next cycle and no further frame-buffer write follows. A control write with both bit 1 and bit 2 set starts nothing.
- R4: The raster-operation code (register 0xC) produces the result as follows. 0x00 gives 0. 0x05 gives src AND dst. 0x06 gives dst. 0x09 gives src AND NOT dst. 0x0B gives NOT dst. 0x0D gives src. Every other code writes back the destination byte unchanged.
- R5: Forward walking (mode bit 0 clear): pixel (x,y) goes to destination D + y·DP + x and reads source S + y·SP + x. W and H are the register values 0x0/0x1 plus one. DP and SP are 16-bit little-endian at 0x2/0x3 and 0x4/0x5. D and S are at 0x6/0x7 and 0x8/0x9.
- R6: With mode bit 0 set, both addresses step backward: D − y·DP − x and S − y·SP − x.
- R7: With mode bit 7 set (colour expansion), the mask byte is read at S + y·SP + x/8 and bit 7 − (x mod 8) is tested. A set bit selects the foreground colour (0xD) and a clear bit selects the background colour (0xE). Extension (0xB) bit 1 inverts the tested bit.
- R8: With extension bit 2 set, every pixel takes the foreground colour and no source byte is read.
- R9: With mode bit 6 set (pattern), the source is read at (S with its low 2 bits cleared) + (y mod 8)·8 + (x mod 8). When bit 7 is also set, the mask byte comes from (S with its low 3 bits cleared) + (y mod 8).
- R10: With mode bit 2 set, pixels come from host words accepted on host_valid with host_ready, least-significant byte first. Bytes left in a word at the end of a row are dropped, and every row starts with a fresh word.
- R11: Status bit 4 is high and host_ready is asserted only while the engine is waiting for a host word.
- R12: While busy, writes to registers other than the control register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register page write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 8 | Register write data |
| status | output | 8 | Bit 0 busy, bit 4 waiting for host word |
| host_valid | input | 1 | Host word offered |
| host_word | input | 32 | Four host pixels, low byte first |
| host_ready | output | 1 | Engine accepts a host word |
| fb_re | output | 1 | Frame-buffer read strobe |
| fb_we | output | 1 | Frame-buffer write strobe |
| fb_addr | output | AW | Frame-buffer byte address |
| fb_wdata | output | 8 | Frame-buffer write data |
| fb_rdata | input | 8 | Read data, one cycle after fb_re |

## Verification
Two pairs of events can meet in one cycle. The first is a start request and a reset request carried in the same control write. The bench writes 0x06 and checks that busy stays low and that the write counter does not move. The second is a register write that lands while the engine is running. The bench aborts a long solid fill mid-way and rewrites the fill colour during another fill. It judges the first case by busy dropping on the next cycle with writes stopping at once, and the second by the whole rectangle keeping the colour sampled at start.

// File: rtl/blit_pkg.sv
package blit_pkg;
   localparam int unsigned REG_COUNT = 16;
   localparam int unsigned PIX_W     = 8;
   localparam int unsigned DIM_W     = 8;

   localparam logic [3:0] RA_CTRL = 4'hF;

   // mode byte bits
   localparam int unsigned MB_BACK = 0;
   localparam int unsigned MB_HOST = 2;
   localparam int unsigned MB_PAT  = 6;
   localparam int unsigned MB_CEXP = 7;
   // extension byte bits
   localparam int unsigned XB_INV   = 1;
   localparam int unsigned XB_SOLID = 2;
   // control byte bits
   localparam int unsigned CB_START = 1;
   localparam int unsigned CB_RESET = 2;

   typedef enum logic [2:0] {
      ST_IDLE, ST_HOST, ST_SRC, ST_DST, ST_WR
   } blit_state_e;

   typedef struct packed {
      logic [7:0]  wm1;
      logic [7:0]  hm1;
      logic [15:0] dpitch;
      logic [15:0] spitch;
      logic [15:0] dbase;
      logic [15:0] sbase;
      logic [7:0]  mode;
      logic [7:0]  ext;
      logic [7:0]  rop;
      logic [7:0]  fg;
      logic [7:0]  bg;
   } blit_cfg_t;

   function automatic logic [PIX_W-1:0] rop_apply(input logic [7:0] code,
                                                  input logic [PIX_W-1:0] s,
                                                  input logic [PIX_W-1:0] d);
      case (code)
         8'h00:   return '0;
         8'h05:   return s & d;
         8'h06:   return d;
         8'h09:   return s & ~d;
         8'h0B:   return ~d;
         8'h0D:   return s;
         default: return d;
      endcase
   endfunction
endpackage

// File: rtl/blit_regs.sv
module blit_regs
   import blit_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [3:0] addr,
   input  logic [7:0] wdata,
   input  logic       busy,
   output blit_cfg_t  cfg,
   output logic       start,
   output logic       abort
);
   logic [7:0] bank [REG_COUNT-1];

   for (genvar i = 0; i < REG_COUNT - 1; i++) begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (we && !busy && addr == 4'(i))
            q <= wdata;
      end
      assign bank[i] = q;
   end

   always_comb begin
      cfg.wm1    = bank[0];
      cfg.hm1    = bank[1];
      cfg.dpitch = {bank[3], bank[2]};
      cfg.spitch = {bank[5], bank[4]};
      cfg.dbase  = {bank[7], bank[6]};
      cfg.sbase  = {bank[9], bank[8]};
      cfg.mode   = bank[10];
      cfg.ext    = bank[11];
      cfg.rop    = bank[12];
      cfg.fg     = bank[13];
      cfg.bg     = bank[14];
   end

   wire ctrl_wr = we && addr == RA_CTRL;
   assign abort = ctrl_wr && wdata[CB_RESET];
   assign start = ctrl_wr && wdata[CB_START] && !wdata[CB_RESET] && !busy;

   // R12: page frozen while an operation runs
   a_r12_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy && we && addr != RA_CTRL |=> $stable(cfg));
endmodule

// File: rtl/blit_pixel.sv
module blit_pixel
   import blit_pkg::*;
#(
   parameter int unsigned AW = 12
) (
   input  logic [AW-1:0]    sbase,
   input  logic [DIM_W-1:0] col,
   input  logic [DIM_W-1:0] row,
   input  logic [AW-1:0]    src_row,
   input  logic             back,
   input  logic             pat,
   input  logic             cexp,
   input  logic             inv,
   input  logic             solid,
   input  logic             host_mode,
   input  logic [7:0]       fg,
   input  logic [7:0]       bg,
   input  logic [7:0]       rop,
   input  logic [PIX_W-1:0] src_q,
   input  logic [PIX_W-1:0] host_byte,
   input  logic [PIX_W-1:0] dst_q,
   output logic [AW-1:0]    src_addr,
   output logic [PIX_W-1:0] result
);
   logic [AW-1:0]    step;
   logic             mask;
   logic [PIX_W-1:0] sval;

   always_comb begin
      step = cexp ? AW'(col[DIM_W-1:3]) : AW'(col);
      if (pat && cexp)
         src_addr = {sbase[AW-1:3], row[2:0]};
      else if (pat)
         src_addr = {sbase[AW-1:2], 2'b00} + AW'({row[2:0], 3'b000}) + AW'(col[2:0]);
      else
         src_addr = back ? src_row - step : src_row + step;

      mask = solid | (src_q[~col[2:0]] ^ inv);
      if (solid || cexp)
         sval = mask ? fg : bg;
      else if (host_mode)
         sval = host_byte;
      else
         sval = src_q;
      result = rop_apply(rop, sval, dst_q);
   end
endmodule

// File: rtl/blit_walker.sv
module blit_walker
   import blit_pkg::*;
#(
   parameter int unsigned AW      = 12,
   parameter bit          HOST_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic [DIM_W-1:0] wm1,
   input  logic [DIM_W-1:0] hm1,
   input  logic [AW-1:0]    dpitch,
   input  logic [AW-1:0]    spitch,
   input  logic [AW-1:0]    dbase,
   input  logic [AW-1:0]    sbase,
   input  logic             back,
   input  logic             solid,
   input  logic             host_mode,
   input  logic             host_valid,
   input  logic [31:0]      host_word,
   input  logic [PIX_W-1:0] fb_rdata,
   input  logic [AW-1:0]    pix_src_addr,
   input  logic [PIX_W-1:0] pix_result,
   output logic             busy,
   output logic             host_wait,
   output logic [DIM_W-1:0] col,
   output logic [DIM_W-1:0] row,
   output logic [AW-1:0]    src_row,
   output logic [PIX_W-1:0] src_q,
   output logic [PIX_W-1:0] host_byte,
   output logic             fb_re,
   output logic             fb_we,
   output logic [AW-1:0]    fb_addr,
   output logic [PIX_W-1:0] fb_wdata
);
   blit_state_e   st_q, st_d;
   logic [AW-1:0] drow_q, srow_q;
   logic [2:0]    hcnt_q, hcnt_nx;
   logic          use_host;

   wire last_col = col == wm1;
   wire last_row = row == hm1;
   wire [AW-1:0] dst_addr = back ? drow_q - AW'(col) : drow_q + AW'(col);

   assign use_host = HOST_EN && host_mode;
   assign hcnt_nx  = last_col ? 3'd0 : hcnt_q - 3'd1;

   function automatic blit_state_e entry(input logic [2:0] hc);
      if (solid)         return ST_DST;
      else if (use_host) return (hc == 3'd0) ? ST_HOST : ST_DST;
      else               return ST_SRC;
   endfunction

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE: if (start) st_d = entry(3'd0);
         ST_HOST: if (host_valid) st_d = ST_DST;
         ST_SRC:  st_d = ST_DST;
         ST_DST:  st_d = ST_WR;
         ST_WR:   st_d = (last_col && last_row) ? ST_IDLE : entry(hcnt_nx);
         default: st_d = ST_IDLE;
      endcase
      if (abort) st_d = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         col    <= '0;
         row    <= '0;
         drow_q <= '0;
         srow_q <= '0;
         src_q  <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && start) begin
            col    <= '0;
            row    <= '0;
            drow_q <= dbase;
            srow_q <= sbase;
         end else if (st_q == ST_WR) begin
            if (last_col) begin
               col    <= '0;
               row    <= row + 1'b1;
               drow_q <= back ? drow_q - dpitch : drow_q + dpitch;
               srow_q <= back ? srow_q - spitch : srow_q + spitch;
            end else begin
               col <= col + 1'b1;
            end
         end
         if (st_q == ST_DST) src_q <= fb_rdata;
      end
   end

   if (HOST_EN) begin : g_host
      logic [31:0] hbuf_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hbuf_q <= '0;
            hcnt_q <= '0;
         end else if (st_q == ST_IDLE) begin
            hcnt_q <= '0;
         end else if (st_q == ST_HOST && host_valid) begin
            hbuf_q <= host_word;
            hcnt_q <= 3'd4;
         end else if (st_q == ST_WR && use_host && !solid) begin
            hbuf_q <= hbuf_q >> 8;
            hcnt_q <= hcnt_nx;
         end
      end
      assign host_byte = hbuf_q[PIX_W-1:0];
   end else begin : g_nohost
      logic unused_host;
      assign unused_host = host_valid ^ (^host_word);
      assign hcnt_q      = '0;
      assign host_byte   = '0;
   end

   assign busy      = st_q != ST_IDLE;
   assign host_wait = st_q == ST_HOST;
   assign src_row   = srow_q;
   assign fb_re     = st_q == ST_SRC || st_q == ST_DST;
   assign fb_we     = st_q == ST_WR;
   assign fb_addr   = (st_q == ST_SRC) ? pix_src_addr : dst_addr;
   assign fb_wdata  = pix_result;

   // R5: the port never reads and writes in one cycle
   a_r5_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(fb_re && fb_we));
   // R10: a host word holds at most four pixels
   a_r10_host_count: assert property (@(posedge clk) disable iff (!rst_n)
      hcnt_q <= 3'd4);
endmodule

// File: rtl/blit_engine.sv
module blit_engine
   import blit_pkg::*;
#(
   parameter int unsigned AW      = 12,
   parameter bit          HOST_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [3:0]    reg_addr,
   input  logic [7:0]    reg_wdata,
   output logic [7:0]    status,
   input  logic          host_valid,
   input  logic [31:0]   host_word,
   output logic          host_ready,
   output logic          fb_re,
   output logic          fb_we,
   output logic [AW-1:0] fb_addr,
   output logic [7:0]    fb_wdata,
   input  logic [7:0]    fb_rdata
);
   if (AW < 8 || AW > 16) begin : g_bad_aw
      $error("blit_engine: AW must lie in 8..16");
   end

   blit_cfg_t        cfg;
   logic             start, abort, busy, host_wait;
   logic [DIM_W-1:0] col, row;
   logic [AW-1:0]    src_row, pix_src_addr;
   logic [PIX_W-1:0] src_q, host_byte, pix_result;
   logic             unused_cfg;

   assign unused_cfg = ^{cfg.mode[5:3], cfg.mode[1], cfg.ext[7:3], cfg.ext[0],
                         cfg.dpitch, cfg.spitch, cfg.dbase, cfg.sbase};

   blit_regs u_regs (
      .clk, .rst_n, .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .busy, .cfg, .start, .abort
   );

   blit_walker #(.AW(AW), .HOST_EN(HOST_EN)) u_walk (
      .clk, .rst_n, .start, .abort,
      .wm1(cfg.wm1), .hm1(cfg.hm1),
      .dpitch(cfg.dpitch[AW-1:0]), .spitch(cfg.spitch[AW-1:0]),
      .dbase(cfg.dbase[AW-1:0]), .sbase(cfg.sbase[AW-1:0]),
      .back(cfg.mode[MB_BACK]), .solid(cfg.ext[XB_SOLID]),
      .host_mode(cfg.mode[MB_HOST]), .host_valid, .host_word, .fb_rdata,
      .pix_src_addr, .pix_result, .busy, .host_wait, .col, .row, .src_row,
      .src_q, .host_byte, .fb_re, .fb_we, .fb_addr, .fb_wdata
   );

   blit_pixel #(.AW(AW)) u_pix (
      .sbase(cfg.sbase[AW-1:0]), .col, .row, .src_row,
      .back(cfg.mode[MB_BACK]), .pat(cfg.mode[MB_PAT]), .cexp(cfg.mode[MB_CEXP]),
      .inv(cfg.ext[XB_INV]), .solid(cfg.ext[XB_SOLID]),
      .host_mode(cfg.mode[MB_HOST] && HOST_EN),
      .fg(cfg.fg), .bg(cfg.bg), .rop(cfg.rop), .src_q, .host_byte,
      .dst_q(fb_rdata), .src_addr(pix_src_addr), .result(pix_result)
   );

   assign status     = {3'b000, host_wait, 3'b000, busy};
   assign host_ready = host_wait;

   a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   a_r3_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !busy && !fb_we);
   a_r2_busy_ends_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(fb_we) || $past(abort));
   a_r11_ready_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> status[0]);
endmodule

// File: tb/blit_engine_bench.sv
module blit_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  status;
   logic        host_valid = 1'b0;
   logic [31:0] host_word = '0;
   logic        host_ready, fb_re, fb_we;
   logic [11:0] fb_addr;
   logic [7:0]  fb_wdata;
   logic [7:0]  fb_rdata = '0;

   logic [7:0]  mem  [4096];
   logic [7:0]  expm [4096];
   logic [31:0] hw   [64];
   int errs = 0, checks = 0, wcnt = 0;
   int g_wm1, g_hm1, g_dp, g_sp, g_dst, g_src, g_mode, g_ext, g_rop, g_fg, g_bg;

   always #2 clk = ~clk;

   blit_engine u_blit_engine (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .status, .host_valid,
      .host_word, .host_ready, .fb_re, .fb_we, .fb_addr, .fb_wdata, .fb_rdata
   );

   always @(posedge clk) begin
      if (fb_we) begin
         mem[fb_addr] <= fb_wdata;
         wcnt <= wcnt + 1;
      end
      if (fb_re) fb_rdata <= mem[fb_addr];
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic wait_idle(input string tag);
      int n = 0;
      while (status[0] && n < 20000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 20000) check(1'b0, {tag, " timeout"}, n, 0);
   endtask

   function automatic int brop(input int code, input int s, input int d);
      case (code)
         'h00: return 0;
         'h05: return s & d;
         'h06: return d;
         'h09: return s & ~d & 'hFF;
         'h0B: return ~d & 'hFF;
         'h0D: return s;
         default: return d;
      endcase
   endfunction

   task automatic setup();
      wr(0, g_wm1); wr(1, g_hm1);
      wr(2, g_dp & 'hFF); wr(3, g_dp >> 8);
      wr(4, g_sp & 'hFF); wr(5, g_sp >> 8);
      wr(6, g_dst & 'hFF); wr(7, g_dst >> 8);
      wr(8, g_src & 'hFF); wr(9, g_src >> 8);
      wr(10, g_mode); wr(11, g_ext); wr(12, g_rop); wr(13, g_fg); wr(14, g_bg);
   endtask

   task automatic model();
      bit back = g_mode[0], host = g_mode[2], pat = g_mode[6], cx = g_mode[7];
      bit sol = g_ext[2], inv = g_ext[1];
      int wpr = (g_wm1 + 4) / 4;
      for (int y = 0; y <= g_hm1; y++) begin
         int drow = back ? g_dst - y * g_dp : g_dst + y * g_dp;
         int srow = back ? g_src - y * g_sp : g_src + y * g_sp;
         for (int x = 0; x <= g_wm1; x++) begin
            int da = (back ? drow - x : drow + x) & 'hFFF;
            int sv = 0, mb = 0;
            if (pat && cx) mb = expm[(g_src & 'hFF8) | (y % 8)];
            else if (pat) sv = expm[((g_src & 'hFFC) + (y % 8) * 8 + x % 8) & 'hFFF];
            else if (cx) mb = expm[(back ? srow - x / 8 : srow + x / 8) & 'hFFF];
            else if (host) sv = (hw[y * wpr + x / 4] >> (8 * (x % 4))) & 'hFF;
            else sv = expm[(back ? srow - x : srow + x) & 'hFFF];
            if (sol) sv = g_fg;
            else if (cx) sv = (((mb >> (7 - x % 8)) & 1) ^ inv) ? g_fg : g_bg;
            expm[da] = 8'(brop(g_rop, sv, expm[da]));
         end
      end
   endtask

   task automatic cmp_mem(input string tag);
      int bad = 0, fa = 0;
      for (int i = 0; i < 4096; i++)
         if (mem[i] !== expm[i]) begin
            if (bad == 0) fa = i;
            bad++;
         end
      check(bad == 0, tag, mem[fa], expm[fa]);
   endtask

   task automatic feed_host(input string tag);
      int idx = 0;
      bit seen = 0;
      while (status[0]) begin
         @(negedge clk);
         if (host_ready && !host_valid) begin
            if (!seen) begin
               seen = 1;
               check(status[4] && status[0], {tag, " R11 wait status"}, status, 8'h11);
            end
            host_valid = 1'b1;
            host_word  = hw[idx];
            idx++;
         end else begin
            host_valid = 1'b0;
         end
      end
      host_valid = 1'b0;
      check(idx == ((g_wm1 + 4) / 4) * (g_hm1 + 1), {tag, " R10 word count"}, idx,
            ((g_wm1 + 4) / 4) * (g_hm1 + 1));
   endtask

   task automatic run(input string tag);
      setup();
      model();
      wr(15, 'h02);
      if (g_mode[2]) feed_host(tag);
      wait_idle(tag);
      @(negedge clk);
      cmp_mem(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4096; i++) begin
         mem[i]  = 8'((i * 29 + 7) ^ (i >> 5));
         expm[i] = mem[i];
      end
      for (int i = 0; i < 64; i++) hw[i] = 32'h9E3779B9 * (i + 1);

      repeat (3) @(negedge clk);
      check(status == 8'h00, "R1 status in reset", status, 0);
      check(!fb_re && !fb_we && !host_ready, "R1 strobes in reset",
            {fb_re, fb_we, host_ready}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(status == 8'h00 && !fb_we, "R1 after reset", status, 0);

      // R5 forward copy
      g_wm1 = 4; g_hm1 = 2; g_dp = 32; g_sp = 20; g_dst = 'h100; g_src = 'h400;
      g_mode = 0; g_ext = 0; g_rop = 'h0D; g_fg = 0; g_bg = 0;
      run("R5 forward copy");

      // R2 busy timing and R8 solid fill
      g_wm1 = 3; g_hm1 = 0; g_dst = 'h1C0; g_ext = 4; g_fg = 'h3C;
      setup();
      model();
      wr(15, 'h02);
      begin
         int n = 0;
         check(status[0], "R2 busy after start", status, 1);
         while (status[0] && n < 100) begin
            n++;
            @(negedge clk);
         end
         check(n == 8, "R2 solid busy cycles", n, 8);
      end
      cmp_mem("R8 solid fill");

      // R4 raster operation sweep
      g_ext = 0; g_mode = 0; g_wm1 = 2; g_hm1 = 1; g_dp = 8; g_sp = 8;
      foreach (hw[k]) if (k < 8) begin
         int codes[8] = '{'h00, 'h05, 'h06, 'h09, 'h0B, 'h0D, 'h0E, 'h50};
         g_rop = codes[k]; g_dst = 'h600 + k * 32; g_src = 'h700 + k * 32;
         run($sformatf("R4 rop %0h", codes[k]));
      end

      // R6 backwards
      g_rop = 'h0D; g_mode = 1; g_wm1 = 5; g_hm1 = 3; g_dp = 16; g_sp = 16;
      g_dst = 'h9F0; g_src = 'hAF0;
      run("R6 backward copy");

      // R7 colour expansion, plain and inverted
      g_mode = 'h80; g_wm1 = 11; g_hm1 = 2; g_sp = 4; g_dp = 16;
      g_src = 'h800; g_dst = 'h200; g_fg = 'hAA; g_bg = 'h55; g_ext = 0;
      run("R7 colour expand");
      g_ext = 2; g_dst = 'h280;
      run("R7 colour expand inverted");

      // R9 pattern tile and monochrome pattern
      g_ext = 0; g_mode = 'h40; g_wm1 = 9; g_hm1 = 9; g_dp = 16;
      g_src = 'h843; g_dst = 'h300;
      run("R9 pattern copy");
      g_mode = 'hC0; g_wm1 = 8; g_hm1 = 8; g_src = 'h80D; g_dst = 'h3C0;
      run("R9 mono pattern");

      // R10 host source, row tail dropped
      g_mode = 'h04; g_wm1 = 5; g_hm1 = 2; g_dp = 8; g_dst = 'hB00; g_rop = 'h0D;
      run("R10 host source");
      check(status == 8'h00 && !host_ready, "R11 idle after host", status, 0);

      // R12 colour write during busy is ignored
      g_mode = 0; g_ext = 4; g_fg = 'h5A; g_wm1 = 15; g_hm1 = 1; g_dp = 16;
      g_dst = 'hC00;
      setup();
      model();
      wr(15, 'h02);
      wr(13, 'h11);
      wait_idle("R12");
      @(negedge clk);
      cmp_mem("R12 write ignored while busy");

      // R3 abort mid-operation
      g_wm1 = 63; g_hm1 = 7; g_dp = 64; g_dst = 'hE00; g_fg = 'hC3;
      setup();
      begin
         int w0, w1;
         w0 = wcnt;
         wr(15, 'h02);
         repeat (40) @(negedge clk);
         wr(15, 'h04);
         check(!status[0], "R3 busy low after abort", status, 0);
         w1 = wcnt;
         check(w1 - w0 > 0 && w1 - w0 < 512, "R3 partial writes", w1 - w0, 20);
         repeat (50) @(negedge clk);
         check(wcnt == w1, "R3 no writes after abort", wcnt, w1);
         // R3 start and reset in one write
         wr(15, 'h06);
         check(!status[0], "R3 start with reset stays idle", status, 0);
         repeat (10) @(negedge clk);
         check(wcnt == w1, "R3 start with reset writes nothing", wcnt, w1);
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule